// File: doc/BRIEF.md
# Programmable Pulse-Per-Second Generator

This block turns a free-running system time into a programmable pulse train. The time source supplies a seconds count, a sub-second count and a strobe that marks each sub-second increment (a "tick"). The host writes a target time, a period register and a high-time register through a simple write port. It then issues a start command. The block waits until system time reaches the target and raises its output. From then on it repeats a pulse of fixed period and high time until the host issues a stop command.

The period and high-time registers are both programmed as "ticks minus one". The target is compared as one number: the seconds count above the sub-second count. The target is therefore in whatever units the sub-second counter uses. With a binary-rollover counter, the host must convert nanoseconds to units of roughly 0.465 ns before writing.

While a start is pending, a busy flag is raised and all configuration writes are refused. A stop command cancels a pending start. During a train, a stop command lets the current high phase finish and then holds the output low.

Top module: `pps_pulse_gen`

## Requirements
- R1: After reset `pulse_out` and `tgt_busy` are both low.
- R2: Writes use the address map 0 = control, 1 = target seconds, 2 = target sub-seconds, 3 = period register, 4 = high-time register. In the control word, bits [3:0] carry the command, bits [5:4] the target mode, and bit 7 the enable. Enable = 1, command = 2 and mode = 2 with legal settings start a pending target, and `tgt_busy` rises on that write's clock edge.
- R3: While `tgt_busy` is high, writes to addresses 1 to 4 are ignored.
- R4: `pulse_out` goes high after the first tick on which {seconds, sub-seconds} is greater than or equal to the target, and `tgt_busy` falls at the same edge. A target already in the past starts on the next tick.
- R5: While running, the period is (period register + 1) ticks, the output is high for the first (high-time register + 1) ticks of each period, and the output changes only on tick edges.
- R6: A stop command (enable = 1, command = 5) given while a start is pending clears `tgt_busy`, and no pulse follows.
- R7: A stop command given during a high phase lets that high phase finish and then holds the output low. A stop command given during a low phase holds the output low at once.
- R8: A start is refused, and `tgt_busy` stays low, when the period register is 0, the high-time register is 0, or the high-time register is not less than the period register.
- R9: A control write with enable = 0, or with a mode other than 2, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_tick | input | 1 | Marks one sub-second increment of system time |
| sys_sec | input | SEC_W | System time, seconds |
| sys_sub | input | SUB_W | System time, sub-second count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DW | Register write data |
| pulse_out | output | 1 | Pulse train output |
| tgt_busy | output | 1 | A start is pending at the target time |

## Verification
The bench aims at the start edge: exactly at a target whose seconds field rolls over, and at a target already in the past. A design that compared for equality would never start in the past-target case, and one that compared the fields separately would start early. It stops the train once in a low phase and once at the start of a high phase. A design without drain logic would truncate the pulse, and one that ignored the stop would emit another period. It also writes new period and target values while a start is pending, checks through the pulse timing that they had no effect, and issues starts with illegal settings, with enable cleared and with a wrong mode. A design that accepted any of these would raise the busy flag or begin pulsing.

// File: rtl/pps_pulse_gen.sv
module pps_pulse_gen #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int CNT_W = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             time_tick,
  input  logic [SEC_W-1:0] sys_sec,
  input  logic [SUB_W-1:0] sys_sub,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             pulse_out,
  output logic             tgt_busy
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TSEC = 3'd1;
  localparam logic [2:0] A_TSUB = 3'd2;
  localparam logic [2:0] A_IVAL = 3'd3;
  localparam logic [2:0] A_WVAL = 3'd4;
  localparam logic [3:0] CMD_GO   = 4'h2;
  localparam logic [3:0] CMD_HALT = 4'h5;
  localparam logic [1:0] MODE_START_ONLY = 2'h2;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_DRAIN} st_t;

  st_t              st;
  logic [SEC_W-1:0] tsec;
  logic [SUB_W-1:0] tsub;
  logic [CNT_W-1:0] ival, wval, cnt;
  logic             out_q;

  wire ctrl_wr  = wr_en && (wr_addr == A_CTRL) && wr_data[7];
  wire go_req   = ctrl_wr && (wr_data[3:0] == CMD_GO) && (wr_data[5:4] == MODE_START_ONLY);
  wire halt_req = ctrl_wr && (wr_data[3:0] == CMD_HALT);
  wire legal    = (ival != '0) && (wval != '0) && (wval < ival);
  wire reached  = {sys_sec, sys_sub} >= {tsec, tsub};
  wire draining = (st == S_DRAIN) || (st == S_RUN && halt_req);
  wire [CNT_W-1:0] cnt_inc = cnt + 1'b1;

  assign pulse_out = out_q;
  assign tgt_busy  = (st == S_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tsec  <= '0;
      tsub  <= '0;
      ival  <= '0;
      wval  <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else begin
      if (wr_en && !tgt_busy) begin
        case (wr_addr)
          A_TSEC:  tsec <= wr_data[SEC_W-1:0];
          A_TSUB:  tsub <= wr_data[SUB_W-1:0];
          A_IVAL:  ival <= wr_data[CNT_W-1:0];
          A_WVAL:  wval <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE:
          if (go_req && legal) st <= S_ARMED;
        S_ARMED:
          if (halt_req) st <= S_IDLE;
          else if (time_tick && reached) begin
            st    <= S_RUN;
            cnt   <= '0;
            out_q <= 1'b1;
          end
        default: begin
          if (st == S_RUN && halt_req && !out_q) begin
            st <= S_IDLE;
          end else begin
            if (draining) st <= S_DRAIN;
            if (time_tick) begin
              if (draining && (cnt >= wval || cnt >= ival)) begin
                st    <= S_IDLE;
                out_q <= 1'b0;
              end else if (cnt >= ival) begin
                cnt   <= '0;
                out_q <= 1'b1;
              end else begin
                cnt   <= cnt_inc;
                out_q <= (cnt_inc <= wval);
              end
            end
          end
        end
      endcase
    end
  end

  a_r6_pending_means_low: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_busy |-> !pulse_out);

  a_r4_start_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tgt_busy) && pulse_out) |-> $past(time_tick && reached));

  a_r5_edges_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out != $past(pulse_out)) |-> $past(time_tick));

  a_r3_locked_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_busy && wr_en && wr_addr == A_IVAL) |=> $stable(ival));

  a_r3_locked_target: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_busy && wr_en && wr_addr == A_TSEC) |=> $stable(tsec));

  a_r8_armed_only_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_busy) |-> (ival != '0 && wval != '0 && wval < ival));

  a_r7_drain_no_new_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |=> !$rose(pulse_out));

endmodule

// File: tb/test_pps_pulse_gen.sv
module test_pps_pulse_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    t;
    bit    v;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  int last_t = -1;
  bit run_time = 0;
  bit done = 0;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        time_tick = 0;
  logic [31:0] sys_sec = '0;
  logic [30:0] sys_sub = '0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pulse_out, tgt_busy;

  pps_pulse_gen i_pps_pulse_gen (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
    .sys_sec(sys_sec), .sys_sub(sys_sub),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_out(pulse_out), .tgt_busy(tgt_busy)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, last_t);
    end
  endtask

  task automatic push(int t, bit v, string tag);
    item_t it;
    it.t = t; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_train(int from, int to, int start, int per, int high, string tag);
    for (int t = from; t <= to; t++)
      push(t, (t >= start) && (((t - start) % per) < high), tag);
  endtask

  task automatic push_low(int from, int to, string tag);
    for (int t = from; t <= to; t++) push(t, 1'b0, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic wait_t(int x);
    wait (last_t >= x);
  endtask

  // time source and scoreboard monitor: ticks every other cycle, t = tick index
  initial begin
    forever @(negedge clk) begin
      if (time_tick) begin
        while (q.size() > 0 && q[0].t <= cur_t) begin
          item_t it;
          it = q.pop_front();
          if (it.t == cur_t) check(it.tag, pulse_out, it.v);
        end
        last_t = cur_t;
        cur_t++;
        time_tick = 0;
      end else if (run_time) begin
        sys_sec = cur_t / 16;
        sys_sub = 31'(cur_t % 16);
        time_tick = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset pulse_out", pulse_out, 0);
    check("R1 reset tgt_busy", tgt_busy, 0);
    rst_n = 1;
    run_time = 1;

    // A: target on a seconds rollover (t=64), period 6, high 3, stop in low phase
    wait_t(5);
    push_train(60, 85, 64, 6, 3, "R5 train A");
    push_low(86, 96, "R7 stop in low phase");
    wr(3'd1, 32'd4);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h0000_00A2);
    check("R2 start raises busy", tgt_busy, 1);
    wr(3'd3, 32'd1);
    wr(3'd1, 32'd9);
    check("R3 busy held after refused writes", tgt_busy, 1);
    wait_t(64);
    check("R4 busy clears at target", tgt_busy, 0);
    check("R4 output high at target", pulse_out, 1);
    wait_t(85);
    wr(3'd0, 32'h0000_0085);
    wait_t(97);

    // B: period 4, high 2, stop right at the start of a high phase
    wait_t(100);
    push_train(108, 121, 112, 4, 2, "R5 train B");
    push_low(122, 130, "R7 stop in high phase");
    wr(3'd3, 32'd3);
    wr(3'd4, 32'd1);
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0000_00A2);
    wait_t(120);
    wr(3'd0, 32'h0000_0085);
    wait_t(131);

    // C: illegal settings refused (target is in the past, so acceptance would pulse)
    wait_t(135);
    push_low(136, 160, "R8 no pulse on illegal settings");
    wr(3'd3, 32'd0); wr(3'd4, 32'd1); wr(3'd0, 32'h0000_00A2);
    check("R8 period 0 refused", tgt_busy, 0);
    wr(3'd3, 32'd5); wr(3'd4, 32'd0); wr(3'd0, 32'h0000_00A2);
    check("R8 high 0 refused", tgt_busy, 0);
    wr(3'd3, 32'd3); wr(3'd4, 32'd3); wr(3'd0, 32'h0000_00A2);
    check("R8 high not below period refused", tgt_busy, 0);

    // D: enable clear or wrong mode starts nothing
    wr(3'd3, 32'd5); wr(3'd4, 32'd2);
    wr(3'd0, 32'h0000_0022);
    check("R9 enable clear ignored", tgt_busy, 0);
    wr(3'd0, 32'h0000_0092);
    check("R9 wrong mode ignored", tgt_busy, 0);
    wait_t(161);

    // E: stop while pending cancels (target t=245 uses sub-seconds)
    wait_t(165);
    push_low(166, 260, "R6 cancelled target gives no pulse");
    wr(3'd1, 32'd15); wr(3'd2, 32'd5);
    wr(3'd0, 32'h0000_00A2);
    check("R6 armed before cancel", tgt_busy, 1);
    wait_t(200);
    wr(3'd0, 32'h0000_0085);
    check("R6 busy cleared by stop", tgt_busy, 0);
    wait_t(261);

    // F: target in the past starts on the next tick
    wait_t(265);
    wr(3'd1, 32'd0); wr(3'd2, 32'd3);
    wait_t(270);
    push_train(271, 285, 271, 6, 3, "R4 past target starts next tick");
    push_low(286, 295, "R7 stop after past-target train");
    wr(3'd0, 32'h0000_00A2);
    wait_t(285);
    wr(3'd0, 32'h0000_0085);
    wait_t(296);

    check("scoreboard drained", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule